// File: doc/BRIEF.md
# Byte-Bus Word Read Cache Filler

This block links a core that thinks in 16-bit words to an external memory bus only one byte wide. A small fully associative cache sits between them. Each line holds 16 bytes, carries a valid bit for every byte, and is tagged with address bits 23 down to 4. The core asks for a byte or a word at a 24-bit address. A word is handled as two byte steps: the requested address first, then the next one.

Each byte step looks in the cache first. If the byte is valid there, the cache supplies it and no bus cycle runs. If it is not, the block runs one bus transaction. The address goes out with a one-cycle strobe. Then read is held until the bus signals ready, and the byte on the data bus is captured in that cycle. The captured byte is stored into the cache byte at that exact address and marked valid.

A tag miss takes a line in round-robin order and clears all of that line's byte-valid bits before the fill. When the cache is disabled, every byte comes from the bus and the cache is left alone. The core gets a one-cycle done pulse with the assembled result.

Top module: `byte_word_cache_filler`

## Requirements
- R1: A word read at an even address with no cached bytes runs exactly two bus transactions, first at the requested address and then at that address plus one. The first byte returned goes to data_o[7:0] and the second to data_o[15:8].
- R2: In each bus transaction, bus_as_o is high for exactly one cycle with the address on bus_addr_o. Then bus_rd_o stays high, with bus_addr_o unchanged, until bus_rdy_i is sampled high. The byte on bus_data_i is captured in that same cycle.
- R3: After a byte is read from the bus with the cache enabled, that exact address holds the captured bus byte and is valid in the cache. Reading 1004h/1005h holding BB/CC leaves BB and CC in the cache, and never the upper address byte (10h).
- R4: A byte that is valid in the cache is returned from the cache, and no bus transaction runs for it. A word whose two bytes are both valid runs no bus transaction.
- R5: A word read whose low byte is cached and whose high byte is not runs exactly one bus transaction, at the high address.
- R6: A word read at an odd address runs two independent byte steps, including when the second byte lies in the next line. Each step follows the hit and fill rules.
- R7: With cache_en_i low, every byte is fetched from the bus. The cache is not consulted, and its contents and valid bits stay unchanged.
- R8: A tag miss allocates one of NUM_LINES lines in round-robin order, with all of its byte-valid bits cleared. With 4 lines, the fifth distinct line evicts the first.
- R9: A one-cycle pulse on inval_i clears every valid bit, and so does reset. Afterwards every byte misses.
- R10: done_o is a single-cycle pulse that comes exactly one cycle after the cycle in which the last byte was captured from the bus or supplied by the cache. data_o holds the result during that pulse, and a byte read leaves data_o[15:8] at zero. Requests are taken only while ready_o is high, and at reset ready_o is 1 and done_o, bus_as_o and bus_rd_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cache_en_i | input | 1 | Cache enable |
| inval_i | input | 1 | Clear all valid bits (single-cycle pulse) |
| req_i | input | 1 | Read request, taken when ready_o is high |
| word_i | input | 1 | 1 = word read, 0 = byte read |
| addr_i | input | 24 | Read address |
| ready_o | output | 1 | Idle, able to take a request |
| done_o | output | 1 | Result valid pulse |
| data_o | output | 16 | Result, low byte at the requested address |
| bus_as_o | output | 1 | Address strobe |
| bus_rd_o | output | 1 | Read active |
| bus_addr_o | output | 24 | Bus byte address |
| bus_rdy_i | input | 1 | Bus data ready |
| bus_data_i | input | 8 | Bus read data |

## Verification
The hardest state to reach is a word read whose two bytes take different paths. One case is a low byte that hits with a high byte that misses. The other is an odd word whose high byte needs a fresh line to be allocated. The stimulus builds this state up in a fixed order:
- a byte read at 1008h is cached alone, then the word at 1008h is read;
- the word at 100Fh crosses into line 1010h.

Cache corruption is exposed by reading back single bytes right after a word fill, with no bus cycle. Each byte must return the captured bus data and not the upper address byte. Untouched cache state under disable is shown by changing the bus memory while the cache is disabled. After the cache is enabled again, a read must still return the old cached value.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_AS,
    ST_RD,
    ST_FIN
  } bwc_state_e;
endpackage

// File: rtl/bwc_tag_match.sv
module bwc_tag_match #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 20,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inval_i,
  input  logic             alloc_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic [IDX_W-1:0] victim_o
);
  logic [NUM_LINES-1:0][TAG_W-1:0] tag_q;
  logic [NUM_LINES-1:0]            lv_q;
  logic [NUM_LINES-1:0]            hit_vec;
  logic [IDX_W-1:0]                ptr_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cmp
    assign hit_vec[i] = lv_q[i] && (tag_q[i] == tag_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (hit_vec[i]) hit_idx_o = IDX_W'(i);
  end

  assign hit_o    = |hit_vec;
  assign victim_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      lv_q  <= '0;
      ptr_q <= '0;
    end else begin
      if (alloc_i) begin
        tag_q[ptr_q] <= tag_i;
        ptr_q        <= (ptr_q == IDX_W'(NUM_LINES-1)) ? '0 : ptr_q + 1'b1;
      end
      if (inval_i)      lv_q        <= '0;
      else if (alloc_i) lv_q[ptr_q] <= 1'b1;
    end
  end

  // R4
  one_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  // R9
  inval_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !hit_o);
endmodule

// File: rtl/bwc_line_store.sv
module bwc_line_store #(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 16,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inval_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_line_i,
  input  logic [IDX_W-1:0] rd_line_i,
  input  logic [OFF_W-1:0] rd_off_i,
  output logic             rd_vld_o,
  output logic [7:0]       rd_data_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_line_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [7:0]       wr_data_i
);
  logic [NUM_LINES-1:0][LINE_BYTES-1:0] vld_q;
  logic [7:0] dat_q [NUM_LINES][LINE_BYTES];

  assign rd_vld_o  = vld_q[rd_line_i][rd_off_i];
  assign rd_data_o = dat_q[rd_line_i][rd_off_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (inval_i) begin
      vld_q <= '0;
    end else begin
      if (clr_en_i) vld_q[clr_line_i] <= '0;
      if (wr_en_i)  vld_q[wr_line_i][wr_off_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) dat_q[wr_line_i][wr_off_i] <= wr_data_i;
  end

  // R3
  fill_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !inval_i && !clr_en_i) |=>
      (vld_q[$past(wr_line_i)][$past(wr_off_i)] &&
       dat_q[$past(wr_line_i)][$past(wr_off_i)] == $past(wr_data_i)));
endmodule

// File: rtl/byte_word_cache_filler.sv
module byte_word_cache_filler
  import bwc_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cache_en_i,
  input  logic              inval_i,
  input  logic              req_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [15:0]       data_o,
  output logic              bus_as_o,
  output logic              bus_rd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_rdy_i,
  input  logic [7:0]        bus_data_i
);
  bwc_state_e        st_q;
  logic [ADDR_W-1:0] base_q, cur_addr;
  logic              word_q, cur_q, fill_q;
  logic [15:0]       res_q;
  logic [IDX_W-1:0]  lidx_q, hit_idx, victim;
  logic              tag_hit, byte_vld, alloc, byte_hit, wr_en, last;
  logic [7:0]        c_data;

  assign cur_addr = base_q + ADDR_W'(cur_q);
  assign last     = !word_q || cur_q;
  assign byte_hit = cache_en_i && tag_hit && byte_vld;
  assign alloc    = (st_q == ST_LOOK) && cache_en_i && !tag_hit;
  assign wr_en    = (st_q == ST_RD) && bus_rdy_i && fill_q;

  bwc_tag_match #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inval_i   (inval_i),
    .alloc_i   (alloc),
    .tag_i     (cur_addr[ADDR_W-1:OFF_W]),
    .hit_o     (tag_hit),
    .hit_idx_o (hit_idx),
    .victim_o  (victim)
  );

  bwc_line_store #(.NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inval_i    (inval_i),
    .clr_en_i   (alloc),
    .clr_line_i (victim),
    .rd_line_i  (hit_idx),
    .rd_off_i   (cur_addr[OFF_W-1:0]),
    .rd_vld_o   (byte_vld),
    .rd_data_o  (c_data),
    .wr_en_i    (wr_en),
    .wr_line_i  (lidx_q),
    .wr_off_i   (cur_addr[OFF_W-1:0]),
    .wr_data_i  (bus_data_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      word_q <= 1'b0;
      cur_q  <= 1'b0;
      fill_q <= 1'b0;
      res_q  <= '0;
      lidx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          base_q <= addr_i;
          word_q <= word_i;
          cur_q  <= 1'b0;
          res_q  <= '0;
          st_q   <= ST_LOOK;
        end
        ST_LOOK: begin
          if (byte_hit) begin
            if (cur_q) res_q[15:8] <= c_data;
            else       res_q[7:0]  <= c_data;
            if (last) st_q  <= ST_FIN;
            else      cur_q <= 1'b1;
          end else begin
            fill_q <= cache_en_i;
            lidx_q <= tag_hit ? hit_idx : victim;
            st_q   <= ST_AS;
          end
        end
        ST_AS: st_q <= ST_RD;
        ST_RD: if (bus_rdy_i) begin
          if (cur_q) res_q[15:8] <= bus_data_i;
          else       res_q[7:0]  <= bus_data_i;
          if (last) st_q <= ST_FIN;
          else begin
            cur_q <= 1'b1;
            st_q  <= ST_LOOK;
          end
        end
        ST_FIN: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o    = (st_q == ST_IDLE);
  assign done_o     = (st_q == ST_FIN);
  assign data_o     = res_q;
  assign bus_as_o   = (st_q == ST_AS);
  assign bus_rd_o   = (st_q == ST_RD);
  assign bus_addr_o = cur_addr;

  // R2
  as_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_as_o |=> (bus_rd_o && !bus_as_o));

  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && !bus_rdy_i) |=> (bus_rd_o && $stable(bus_addr_o)));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));

  // R7
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOK && !cache_en_i) |=> bus_as_o);
endmodule

// File: tb/tb_byte_word_cache_filler.sv
module tb_byte_word_cache_filler;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cache_en = 1'b1, inval = 1'b0, req = 1'b0, word = 1'b0;
  logic [23:0] addr = '0;
  logic        ready, done, bus_as, bus_rd, bus_rdy = 1'b0;
  logic [15:0] data;
  logic [23:0] bus_addr;
  logic [7:0]  bus_data = '0;

  int unsigned cyc = 0, txn = 0, rdy_cyc = 0, r2_bad = 0;
  int unsigned n_chk = 0, n_fail = 0, wait_cnt = 0, lat = 0;
  logic [7:0]  mem_xor = '0;
  logic [23:0] log_a [4];
  logic [23:0] as_addr = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  byte_word_cache_filler dut (
    .clk_i(clk), .rst_ni(rst_n), .cache_en_i(cache_en), .inval_i(inval),
    .req_i(req), .word_i(word), .addr_i(addr), .ready_o(ready), .done_o(done),
    .data_o(data), .bus_as_o(bus_as), .bus_rd_o(bus_rd), .bus_addr_o(bus_addr),
    .bus_rdy_i(bus_rdy), .bus_data_i(bus_data)
  );

  function automatic logic [7:0] memv(input logic [23:0] a);
    if (a == 24'h001004)      return 8'hBB ^ mem_xor;
    else if (a == 24'h001005) return 8'hCC ^ mem_xor;
    else return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C ^ mem_xor;
  endfunction

  // bus responder, acts 1 ns after each rising edge
  logic prev_as = 1'b0;
  initial begin
    forever begin
      @(posedge clk); #1;
      if (bus_as) begin
        if (prev_as) r2_bad++;
        log_a[txn % 4] = bus_addr;
        as_addr = bus_addr;
        lat = txn % 3;
        wait_cnt = 0;
        txn++;
      end
      prev_as = bus_as;
      if (bus_rd && !bus_rdy) begin
        if (bus_addr != as_addr) r2_bad++;
        if (wait_cnt == lat) begin
          bus_rdy  = 1'b1;
          bus_data = memv(bus_addr);
          rdy_cyc  = cyc;
        end else wait_cnt++;
      end else bus_rdy = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic w, input logic [23:0] a,
                         output logic [15:0] d, output int unsigned ntx,
                         output int unsigned lt, output int unsigned dc,
                         output int unsigned t0);
    int unsigned c0;
    @(negedge clk);
    req = 1'b1; word = w; addr = a; c0 = cyc; t0 = txn;
    @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    d = data; ntx = txn - t0; lt = cyc - c0; dc = cyc;
    @(negedge clk);
    chk("R10 done single pulse", {31'b0, done}, 32'd0);
  endtask

  function automatic logic [15:0] expv(input logic w, input logic [23:0] a);
    return w ? {memv(a + 24'd1), memv(a)} : {8'h00, memv(a)};
  endfunction

  // checks data, transaction count and done timing for one read
  task automatic rd_chk(input string tag, input logic w, input logic [23:0] a,
                        input int unsigned exp_tx);
    logic [15:0] d;
    int unsigned ntx, lt, dc, t0;
    do_read(w, a, d, ntx, lt, dc, t0);
    chk({tag, " data"}, {16'b0, d}, {16'b0, expv(w, a)});
    chk({tag, " bus transactions"}, ntx, exp_tx);
    if (exp_tx == 0) chk("R10 hit latency", lt, w ? 32'd3 : 32'd2);
    else             chk("R10 done after last capture", dc, rdy_cyc + 1);
    if (exp_tx == 2) begin
      chk({tag, " first address"}, {8'b0, log_a[t0 % 4]}, {8'b0, a});
      chk({tag, " second address"}, {8'b0, log_a[(t0 + 1) % 4]}, {8'b0, a + 24'd1});
    end
  endtask

  // {word, addr, expected bus transactions}
  localparam logic [26:0] VEC [9] = '{
    {1'b1, 24'h001004, 2'd2},
    {1'b0, 24'h001004, 2'd0},
    {1'b0, 24'h001005, 2'd0},
    {1'b1, 24'h001004, 2'd0},
    {1'b0, 24'h001008, 2'd1},
    {1'b1, 24'h001008, 2'd1},
    {1'b1, 24'h00100F, 2'd2},
    {1'b1, 24'h00100F, 2'd0},
    {1'b1, 24'h001006, 2'd2}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 8:    return "R1";
      1, 2, 4: return "R3";
      3:       return "R4";
      5:       return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset ready", {31'b0, ready}, 32'd1);
    chk("R10 reset done", {31'b0, done}, 32'd0);
    chk("R2 reset strobe/read", {30'b0, bus_as, bus_rd}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 9; i++)
      rd_chk(vtag(i), VEC[i][26], VEC[i][25:2], {30'b0, VEC[i][1:0]});

    // R8: lines 001000, 001010 held; three more allocations wrap to 001000
    rd_chk("R8 fill L2", 1'b0, 24'h002000, 1);
    rd_chk("R8 fill L3", 1'b0, 24'h003000, 1);
    rd_chk("R8 evict first", 1'b0, 24'h004000, 1);
    rd_chk("R8 second line kept", 1'b0, 24'h001010, 0);
    rd_chk("R8 first line evicted", 1'b0, 24'h001004, 1);

    // R9 invalidate-all and reset
    rd_chk("R9 cached before", 1'b0, 24'h003000, 0);
    @(negedge clk); inval = 1'b1;
    @(negedge clk); inval = 1'b0;
    rd_chk("R9 after invalidate", 1'b0, 24'h003000, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R9 after reset", 1'b0, 24'h003000, 1);

    // R7 cache disabled
    rd_chk("R7 prefill", 1'b0, 24'h005000, 1);
    @(negedge clk); cache_en = 1'b0; mem_xor = 8'hFF;
    rd_chk("R7 disabled byte from bus", 1'b0, 24'h005000, 1);
    rd_chk("R7 disabled word from bus", 1'b1, 24'h005000, 2);
    rd_chk("R7 disabled uncached", 1'b0, 24'h006000, 1);
    @(negedge clk); cache_en = 1'b1; mem_xor = 8'h00;
    rd_chk("R7 cache unchanged", 1'b0, 24'h005000, 0);
    rd_chk("R7 no fill while disabled", 1'b0, 24'h006000, 1);

    chk("R2 strobe one cycle, address held", r2_bad, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule